// File: doc/BRIEF.md
# Exception Priority and Vector Generator

This block takes the exception requests a processor core raises (a reset request, data abort, address exception, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt) and, when several are pending together, picks one by a fixed priority. The winner is turned into a vector fetch address, a 5-bit processor mode code and two flags. The flags tell the core which interrupt disables to set on entry.

The fetch address is a base plus the exception's word offset. The base is either all zeros or the high base 0xFFFF0000, chosen by a configuration input. The chosen selection is registered and held, with a valid flag, until the core accepts it. Requests that arrive while a selection is held are not lost. They are considered as soon as the held selection has been accepted and cleared. The interrupt disable bits come in as inputs and mask the two interrupt sources. A 32-bit mode input suppresses the legacy address exception.

Top module: `exc_vector_unit`

## Requirements
- R1: After the system reset (`rst_n` low), `vec_valid` is low and stays low while no request is eligible.
- R2: `vec_addr` equals the base plus four times the exception index. The base is 0x00000000 when `cfg_high_base` is 0 and 0xFFFF0000 when it is 1. The index (`vec_kind`) is: 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 address exception, 6 IRQ, 7 FIQ.
- R3: Among eligible requests, the winner is chosen in this order, highest first: reset, data abort / address exception, FIQ, IRQ, prefetch abort, software interrupt / undefined instruction.
- R4: Within a shared level, data abort beats address exception, and software interrupt beats undefined instruction.
- R5: While `req_reset` is high, no selection is made. On the first clock edge after `req_reset` returns low, the reset vector (index 0) becomes valid.
- R6: When `cfg_mode32` is 1, `req_addrexc` has no effect.
- R7: `req_fiq` has no effect while `f_disable` is 1, and `req_irq` has no effect while `i_disable` is 1.
- R8: `vec_mode` is 0x13 for reset, software interrupt and address exception. It is 0x17 for both aborts, 0x1B for undefined instruction, 0x12 for IRQ and 0x11 for FIQ.
- R9: `vec_set_i` is 1 for every selection. `vec_set_f` is 1 only for reset and FIQ.
- R10: A selection becomes valid on the first edge after its requests are presented while nothing is held. It stays unchanged while `take_accept` is low. `vec_valid` falls on the edge where `take_accept` is high. A request still present then wins on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_high_base | input | 1 | 1 selects base 0xFFFF0000, 0 selects base 0 |
| cfg_mode32 | input | 1 | 1 suppresses the address exception request |
| f_disable | input | 1 | Masks the FIQ request |
| i_disable | input | 1 | Masks the IRQ request |
| req_reset | input | 1 | Reset request, vector taken when it falls |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_dabort | input | 1 | Data abort request |
| req_addrexc | input | 1 | Address exception request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| take_accept | input | 1 | Core accepts the held selection |
| vec_valid | output | 1 | A selection is held |
| vec_kind | output | 3 | Index of the selected exception |
| vec_addr | output | ADDR_W | Vector fetch address |
| vec_mode | output | 5 | Mode code to enter |
| vec_set_i | output | 1 | Set the IRQ disable on entry |
| vec_set_f | output | 1 | Set the FIQ disable on entry |

## Verification
Every selection result (index, address, mode and flags) is due one clock edge after the requests are applied with nothing held. The fall of `vec_valid` is due on the edge that sees `take_accept`. The reset vector appears one edge after `req_reset` drops. The bench drives inputs on the falling edge and samples on the following falling edge, so exactly one rising edge lies between each stimulus and its check. The bench sweeps every combination of the seven ordinary requests against both bases, both 32-bit settings and all four mask combinations. It then checks the hold, the pending behaviour and the reset-release timing over the specific cycle counts listed above.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned NUM_EXC = 8;
    localparam int unsigned KIND_W  = $clog2(NUM_EXC);
    localparam int unsigned MODE_W  = 5;

    typedef enum logic [KIND_W-1:0] {
        EXC_RST  = 3'd0,
        EXC_UND  = 3'd1,
        EXC_SWI  = 3'd2,
        EXC_PABT = 3'd3,
        EXC_DABT = 3'd4,
        EXC_ADDR = 3'd5,
        EXC_IRQ  = 3'd6,
        EXC_FIQ  = 3'd7
    } exc_kind_e;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

    // rank 0 is the highest priority; order matters
    function automatic exc_kind_e kind_at_rank(input int unsigned rank);
        case (rank)
            0:       return EXC_RST;
            1:       return EXC_DABT;
            2:       return EXC_ADDR;
            3:       return EXC_FIQ;
            4:       return EXC_IRQ;
            5:       return EXC_PABT;
            6:       return EXC_SWI;
            default: return EXC_UND;
        endcase
    endfunction

endpackage

// File: rtl/exc_req_gate.sv
module exc_req_gate
    import exc_pkg::*;
#(
    parameter int unsigned N = NUM_EXC
) (
    input  logic [N-1:0] raw_req,
    input  logic         mode32,
    input  logic         fiq_off,
    input  logic         irq_off,
    input  logic         hold_off,
    output logic [N-1:0] elig_req
);
    for (genvar k = 0; k < N; k++) begin : g_gate
        logic kill;
        if (k == int'(EXC_ADDR)) begin : g_addr
            assign kill = mode32;
        end else if (k == int'(EXC_FIQ)) begin : g_fiq
            assign kill = fiq_off;
        end else if (k == int'(EXC_IRQ)) begin : g_irq
            assign kill = irq_off;
        end else begin : g_plain
            assign kill = 1'b0;
        end
        assign elig_req[k] = raw_req[k] & ~kill & ~hold_off;
    end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_pkg::*;
#(
    parameter int unsigned N = NUM_EXC
) (
    input  logic [N-1:0] elig_req,
    output logic         any_req,
    output exc_kind_e    win_kind
);
    always_comb begin
        any_req  = 1'b0;
        win_kind = EXC_RST;
        // walk from lowest rank to highest so the highest overwrites last
        for (int r = N - 1; r >= 0; r--) begin
            if (elig_req[kind_at_rank(r)]) begin
                any_req  = 1'b1;
                win_kind = kind_at_rank(r);
            end
        end
    end
endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
    import exc_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  LOW_BASE  = '0,
    parameter logic [ADDR_W-1:0]  HIGH_BASE = 32'hFFFF_0000
) (
    input  exc_kind_e          kind,
    input  logic               high_base,
    output logic [ADDR_W-1:0]  addr,
    output logic [MODE_W-1:0]  mode,
    output logic               set_i,
    output logic               set_f
);
    localparam int unsigned OFS_W = KIND_W + 2;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        base   = high_base ? HIGH_BASE : LOW_BASE;
        offset = ADDR_W'({kind, 2'b00});
        addr   = base + offset;
        set_i  = 1'b1;
        set_f  = (kind == EXC_RST) || (kind == EXC_FIQ);
        case (kind)
            EXC_RST, EXC_SWI, EXC_ADDR: mode = MODE_SVC;
            EXC_PABT, EXC_DABT:         mode = MODE_ABT;
            EXC_UND:                    mode = MODE_UND;
            EXC_IRQ:                    mode = MODE_IRQ;
            default:                    mode = MODE_FIQ;
        endcase
    end

    logic [OFS_W-1:0] unused_ofs;
    assign unused_ofs = offset[OFS_W-1:0];
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] LOW_BASE  = '0,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_high_base,
    input  logic              cfg_mode32,
    input  logic              f_disable,
    input  logic              i_disable,
    input  logic              req_reset,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic              req_pabort,
    input  logic              req_dabort,
    input  logic              req_addrexc,
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic              take_accept,
    output logic              vec_valid,
    output logic [2:0]        vec_kind,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [4:0]        vec_mode,
    output logic              vec_set_i,
    output logic              vec_set_f
);
    typedef struct packed {
        logic               valid;
        logic               rst_hold;
        exc_kind_e          kind;
        logic [ADDR_W-1:0]  addr;
        logic [MODE_W-1:0]  mode;
        logic               set_i;
        logic               set_f;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NUM_EXC-1:0] raw_req;
    logic [NUM_EXC-1:0] elig_req;
    logic               any_req;
    exc_kind_e          win_kind;
    logic [ADDR_W-1:0]  map_addr;
    logic [MODE_W-1:0]  map_mode;
    logic               map_set_i;
    logic               map_set_f;

    always_comb begin
        raw_req                 = '0;
        raw_req[EXC_RST]        = st_q.rst_hold & ~req_reset;
        raw_req[EXC_UND]        = req_undef;
        raw_req[EXC_SWI]        = req_swi;
        raw_req[EXC_PABT]       = req_pabort;
        raw_req[EXC_DABT]       = req_dabort;
        raw_req[EXC_ADDR]       = req_addrexc;
        raw_req[EXC_IRQ]        = req_irq;
        raw_req[EXC_FIQ]        = req_fiq;
    end

    exc_req_gate #(.N(NUM_EXC)) i_gate (
        .raw_req  (raw_req),
        .mode32   (cfg_mode32),
        .fiq_off  (f_disable),
        .irq_off  (i_disable),
        .hold_off (req_reset),
        .elig_req (elig_req)
    );

    exc_prio_pick #(.N(NUM_EXC)) i_pick (
        .elig_req (elig_req),
        .any_req  (any_req),
        .win_kind (win_kind)
    );

    exc_vec_map #(
        .ADDR_W    (ADDR_W),
        .LOW_BASE  (LOW_BASE),
        .HIGH_BASE (HIGH_BASE)
    ) i_map (
        .kind      (win_kind),
        .high_base (cfg_high_base),
        .addr      (map_addr),
        .mode      (map_mode),
        .set_i     (map_set_i),
        .set_f     (map_set_f)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rst_hold = st_q.rst_hold | req_reset;
        if (st_q.valid) begin
            if (take_accept) begin
                st_d.valid = 1'b0;
            end
        end else if (any_req) begin
            st_d.valid = 1'b1;
            st_d.kind  = win_kind;
            st_d.addr  = map_addr;
            st_d.mode  = map_mode;
            st_d.set_i = map_set_i;
            st_d.set_f = map_set_f;
            if (win_kind == EXC_RST) begin
                st_d.rst_hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_valid = st_q.valid;
    assign vec_kind  = st_q.kind;
    assign vec_addr  = st_q.addr;
    assign vec_mode  = st_q.mode;
    assign vec_set_i = st_q.set_i;
    assign vec_set_f = st_q.set_f;
endmodule

// File: rtl/exc_vector_checker.sv
module exc_vector_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_reset,
    input logic              f_disable,
    input logic              i_disable,
    input logic              take_accept,
    input logic              vec_valid,
    input logic [2:0]        vec_kind,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [4:0]        vec_mode,
    input logic              vec_set_i,
    input logic              vec_set_f
);
    assert_addr_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[1:0] == 2'b00 && vec_addr[4:2] == vec_kind));

    assert_reset_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_reset && !vec_valid) |=> !vec_valid);

    assert_fiq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_valid) && vec_kind == 3'd7) |-> $past(!f_disable));

    assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_valid) && vec_kind == 3'd6) |-> $past(!i_disable));

    assert_fiq_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_kind == 3'd7) |-> vec_mode == 5'h11);

    assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_set_i && (vec_set_f == (vec_kind == 3'd0 || vec_kind == 3'd7))));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !take_accept) |=> (vec_valid && $stable(vec_addr) && $stable(vec_mode)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && take_accept) |=> !vec_valid);
endmodule

bind exc_vector_unit exc_vector_checker #(.ADDR_W(ADDR_W)) i_exc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_reset   (req_reset),
    .f_disable   (f_disable),
    .i_disable   (i_disable),
    .take_accept (take_accept),
    .vec_valid   (vec_valid),
    .vec_kind    (vec_kind),
    .vec_addr    (vec_addr),
    .vec_mode    (vec_mode),
    .vec_set_i   (vec_set_i),
    .vec_set_f   (vec_set_f)
);

// File: tb/test_exc_vector_unit.sv
module test_exc_vector_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_high_base = 1'b0, cfg_mode32 = 1'b0;
    logic        f_disable = 1'b0, i_disable = 1'b0;
    logic        req_reset = 1'b0;
    logic [6:0]  rq = '0; // b0 und,b1 swi,b2 pabt,b3 dabt,b4 addr,b5 irq,b6 fiq
    logic        take_accept = 1'b0;
    logic        vec_valid, vec_set_i, vec_set_f;
    logic [2:0]  vec_kind;
    logic [31:0] vec_addr;
    logic [4:0]  vec_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exc_vector_unit i_exc_vector_unit (
        .clk(clk), .rst_n(rst_n), .cfg_high_base(cfg_high_base), .cfg_mode32(cfg_mode32),
        .f_disable(f_disable), .i_disable(i_disable), .req_reset(req_reset),
        .req_undef(rq[0]), .req_swi(rq[1]), .req_pabort(rq[2]), .req_dabort(rq[3]),
        .req_addrexc(rq[4]), .req_irq(rq[5]), .req_fiq(rq[6]), .take_accept(take_accept),
        .vec_valid(vec_valid), .vec_kind(vec_kind), .vec_addr(vec_addr), .vec_mode(vec_mode),
        .vec_set_i(vec_set_i), .vec_set_f(vec_set_f)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_kind(input logic [6:0] r, input logic m32, input logic fd, input logic id);
        if (r[3])        return 4;
        if (r[4] && !m32) return 5;
        if (r[6] && !fd) return 7;
        if (r[5] && !id) return 6;
        if (r[2])        return 3;
        if (r[1])        return 2;
        if (r[0])        return 1;
        return -1;
    endfunction

    function automatic logic [4:0] exp_mode(input int k);
        case (k)
            0, 2, 5: return 5'h13;
            3, 4:    return 5'h17;
            1:       return 5'h1B;
            6:       return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    task automatic chk_sel(input int k);
        logic [31:0] base;
        base = cfg_high_base ? 32'hFFFF0000 : 32'h0;
        chk("R10 valid", {31'd0, vec_valid}, 32'd1);
        chk("R3 R4 R6 R7 kind", {29'd0, vec_kind}, k[31:0]);
        chk("R2 addr", vec_addr, base + 32'(4 * k));
        chk("R8 mode", {27'd0, vec_mode}, {27'd0, exp_mode(k)});
        chk("R9 set_i", {31'd0, vec_set_i}, 32'd1);
        chk("R9 set_f", {31'd0, vec_set_f}, {31'd0, (k == 0 || k == 7)});
    endtask

    task automatic release_sel();
        take_accept = 1'b1;
        rq = '0;
        step();
        chk("R10 fall", {31'd0, vec_valid}, 32'd0);
        take_accept = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset valid", {31'd0, vec_valid}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 idle valid", {31'd0, vec_valid}, 32'd0);

        // sweep: base x mode32 x masks x all request combinations
        for (int cfg = 0; cfg < 16; cfg++) begin
            cfg_high_base = cfg[0];
            cfg_mode32    = cfg[1];
            f_disable     = cfg[2];
            i_disable     = cfg[3];
            for (int v = 0; v < 128; v++) begin
                int k;
                rq = v[6:0];
                k = exp_kind(rq, cfg_mode32, f_disable, i_disable);
                step();
                if (k < 0) begin
                    chk("R1 R6 R7 nothing eligible", {31'd0, vec_valid}, 32'd0);
                    rq = '0;
                end else begin
                    chk_sel(k);
                    release_sel();
                end
            end
        end

        // hold: selection stable while not accepted; pending request wins after release
        cfg_high_base = 1'b1; cfg_mode32 = 1'b0; f_disable = 1'b0; i_disable = 1'b0;
        rq = 7'b0000010;  // swi
        step();
        chk_sel(2);
        rq = 7'b1001010;  // dabt + fiq + swi arrive while held
        for (int c = 0; c < 3; c++) begin
            step();
            chk("R10 held addr", vec_addr, 32'hFFFF0008);
            chk("R10 held valid", {31'd0, vec_valid}, 32'd1);
        end
        take_accept = 1'b1;
        step();
        chk("R10 fall on accept", {31'd0, vec_valid}, 32'd0);
        take_accept = 1'b0;
        step();
        chk_sel(4);       // pending data abort now wins (R10, R3)
        release_sel();

        // reset request: blocks while high, taken one edge after it falls
        cfg_high_base = 1'b0;
        req_reset = 1'b1;
        rq = 7'b0100000;  // irq also pending
        for (int c = 0; c < 3; c++) begin
            step();
            chk("R5 blocked", {31'd0, vec_valid}, 32'd0);
        end
        req_reset = 1'b0;
        step();
        chk_sel(0);
        chk("R5 reset addr", vec_addr, 32'h0);
        take_accept = 1'b1;
        step();
        chk("R10 reset released", {31'd0, vec_valid}, 32'd0);
        take_accept = 1'b0;
        step();
        chk_sel(6);       // R5: reset taken only once, irq follows
        release_sel();

        // reset release with high base
        cfg_high_base = 1'b1;
        req_reset = 1'b1;
        step();
        req_reset = 1'b0;
        step();
        chk("R5 R2 high reset addr", vec_addr, 32'hFFFF0000);
        chk("R5 valid", {31'd0, vec_valid}, 32'd1);
        release_sel();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule